// File: doc/BRIEF.md
# Ring Node Packet Forwarder

This block is the forwarding stage of one node on a one-way ring of daisy-chained nodes. Frames arrive from the upstream neighbour, pass through a delay line exactly one frame long, and leave toward the downstream neighbour. A frame that carries this node's own identity has been all the way round the ring, so it is removed here. A frame that arrived with a link or checksum fault on any word is also removed, and the node can raise an error interrupt for it. While a frame is still in the delay line, its fate is not yet known. The last word of each frame settles it.

Local traffic waits in a small word queue. A local frame is sent only when the delay line holds no live upstream words, so upstream traffic always has priority. A local frame can also fill the slot left behind by a removed frame. When one of this node's own frames comes back intact, a ring-alive flag is set, which shows that the loop is closed. A frame with the measurement bit set also starts a cycle counter, and its return stops the counter, which gives a round-trip latency reading.

Top module: `ringfwd_node`

## Requirements
- R1: Every frame is exactly FRAME_LEN words long. The first word carries sop and the last carries eop. Header bits [7:0] hold the originator identity and header bit 8 is the measurement marker. On tx, the words of a frame come in consecutive cycles and frames never interleave.
- R2: A received frame whose header bits [7:0] equal node_id is never retransmitted.
- R3: An error-free frame from any other node is sent on tx unchanged. Its first word appears FRAME_LEN rising edges after the edge that samples its first word on rx.
- R4: A frame with rx_err high on any of its words is not retransmitted. When err_irq_en is high, err_irq pulses for one cycle just after the edge that samples the frame's last word. When err_irq_en is low, err_irq stays low.
- R5: A local frame leaves with node_id written into header bits [7:0] and its other bits unchanged. It starts only when no upstream frame would overlap it, so upstream frames already in progress go first. It may occupy the slot freed by a removed frame.
- R6: loc_ready is low while the queue holds QUEUE_FRAMES*FRAME_LEN words.
- R7: ring_alive is set when a frame carrying node_id returns without error. A pulse on alive_clr clears it. When both happen on the same edge, the set wins.
- R8: lat_value is the number of rising edges from the edge that drives a marked local header onto tx up to and including the edge that samples that frame's last word on return. lat_busy is high while a measurement is in progress.
- R9: After reset, tx_valid, err_irq, ring_alive and lat_busy are low, lat_value is 0 and loc_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| node_id | input | 8 | Identity of this node, fixed by strapping |
| rx_valid | input | 1 | Upstream word valid |
| rx_sop | input | 1 | Upstream first word of frame |
| rx_eop | input | 1 | Upstream last word of frame |
| rx_data | input | 32 | Upstream word |
| rx_err | input | 1 | Link or checksum fault on this word |
| loc_valid | input | 1 | Local word offered to the queue |
| loc_data | input | 32 | Local word |
| loc_ready | output | 1 | Queue can take a word |
| tx_valid | output | 1 | Downstream word valid |
| tx_sop | output | 1 | Downstream first word of frame |
| tx_eop | output | 1 | Downstream last word of frame |
| tx_data | output | 32 | Downstream word |
| err_irq_en | input | 1 | Enables the error interrupt |
| err_irq | output | 1 | One-cycle pulse per removed faulty frame |
| alive_clr | input | 1 | Clears the ring-alive flag |
| ring_alive | output | 1 | Own frame has completed the loop |
| lat_value | output | CNT_W | Last round-trip latency in cycles |
| lat_busy | output | 1 | Latency measurement in progress |

## Verification
Two pairs of events can land on the same edge. In the first, alive_clr is held high during the cycle in which the last word of a returning own frame is sampled, and ring_alive must read 1 afterwards. In the second, a local frame becomes ready while an upstream stream is passing, and an own frame in the middle of that stream is removed. The local frame must then occupy exactly the freed slot: the order on tx is judged by header, and every tx word is checked to belong to a complete, uninterrupted frame.

// File: rtl/ringfwd_pkg.sv
package ringfwd_pkg;
    localparam int DATA_W   = 32;
    localparam int ID_W     = 8;
    localparam int MARK_BIT = 8;

    typedef struct packed {
        logic              vld;
        logic              sop;
        logic              eop;
        logic [DATA_W-1:0] data;
    } word_t;
endpackage

// File: rtl/ringfwd_delay.sv
module ringfwd_delay
    import ringfwd_pkg::*;
#(
    parameter int FRAME_LEN = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  word_t           in_word,
    input  logic            in_err,
    input  logic [ID_W-1:0] node_id,
    output word_t           out_word,
    output logic            line_busy,
    output logic            fin,
    output logic            fin_own,
    output logic            fin_err,
    output logic            fin_mark
);
    typedef struct packed {
        word_t [FRAME_LEN-1:0] stg;
        logic  [FRAME_LEN-1:0] kill;
        logic                  acc_err;
        logic                  acc_own;
        logic                  acc_mark;
    } state_t;

    state_t q, d;

    always_comb begin
        d = q;
        // verdict so far, including the word on the input this cycle
        fin_err  = in_err | (in_word.sop ? 1'b0 : q.acc_err);
        fin_own  = in_word.sop ? (in_word.data[ID_W-1:0] == node_id) : q.acc_own;
        fin_mark = in_word.sop ? in_word.data[MARK_BIT] : q.acc_mark;
        fin      = in_word.vld && in_word.eop;

        d.stg[0]  = in_word;
        d.kill[0] = 1'b0;
        for (int i = 1; i < FRAME_LEN; i++) begin
            d.stg[i]  = q.stg[i-1];
            d.kill[i] = q.kill[i-1];
        end
        if (in_word.vld) begin
            d.acc_err  = fin_err;
            d.acc_own  = fin_own;
            d.acc_mark = fin_mark;
        end
        // whole frame sits in the line after this edge: strike it out
        if (fin && (fin_err || fin_own)) begin
            d.kill = '1;
        end

        line_busy = 1'b0;
        for (int i = 0; i < FRAME_LEN; i++) begin
            line_busy = line_busy | (q.stg[i].vld & ~q.kill[i]);
        end

        out_word     = q.stg[FRAME_LEN-1];
        out_word.vld = q.stg[FRAME_LEN-1].vld & ~q.kill[FRAME_LEN-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/ringfwd_lqueue.sv
module ringfwd_lqueue
    import ringfwd_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int FRAME_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              frame_avail,
    output logic              not_full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [AW-1:0]                wp;
        logic [AW-1:0]                rp;
        logic [CW-1:0]                cnt;
    } state_t;

    state_t q, d;
    logic   do_push, do_pop;

    always_comb begin
        d       = q;
        do_push = push && (q.cnt != CW'(DEPTH));
        do_pop  = pop && (q.cnt != '0);
        if (do_push) begin
            d.mem[q.wp] = push_data;
            d.wp        = (q.wp == AW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
        end
        if (do_pop) begin
            d.rp = (q.rp == AW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
        head        = q.mem[q.rp];
        frame_avail = q.cnt >= CW'(FRAME_LEN);
        not_full    = q.cnt != CW'(DEPTH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/ringfwd_monitor.sv
module ringfwd_monitor #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fin,
    input  logic             fin_own,
    input  logic             fin_err,
    input  logic             fin_mark,
    input  logic             start_mark,
    input  logic             alive_clr,
    input  logic             irq_en,
    output logic             ring_alive,
    output logic             err_irq,
    output logic [CNT_W-1:0] lat_value,
    output logic             lat_busy
);
    typedef struct packed {
        logic             alive;
        logic             irq;
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lat;
    } state_t;

    state_t           q, d;
    logic             good_ret;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        d        = q;
        good_ret = fin && fin_own && !fin_err;
        cnt_inc  = (q.cnt == '1) ? q.cnt : q.cnt + 1'b1;
        d.irq    = fin && fin_err && irq_en;
        if (alive_clr) begin
            d.alive = 1'b0;
        end
        if (good_ret) begin
            d.alive = 1'b1;
        end
        if (q.run) begin
            if (good_ret && fin_mark) begin
                d.lat = cnt_inc;
                d.run = 1'b0;
            end else begin
                d.cnt = cnt_inc;
            end
        end else if (start_mark) begin
            d.run = 1'b1;
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ring_alive = q.alive;
    assign err_irq    = q.irq;
    assign lat_value  = q.lat;
    assign lat_busy   = q.run;
endmodule

// File: rtl/ringfwd_node.sv
module ringfwd_node
    import ringfwd_pkg::*;
#(
    parameter int FRAME_LEN    = 4,
    parameter int QUEUE_FRAMES = 2,
    parameter int CNT_W        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   node_id,
    input  logic              rx_valid,
    input  logic              rx_sop,
    input  logic              rx_eop,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_err,
    input  logic              loc_valid,
    input  logic [DATA_W-1:0] loc_data,
    output logic              loc_ready,
    output logic              tx_valid,
    output logic              tx_sop,
    output logic              tx_eop,
    output logic [DATA_W-1:0] tx_data,
    input  logic              err_irq_en,
    output logic              err_irq,
    input  logic              alive_clr,
    output logic              ring_alive,
    output logic [CNT_W-1:0]  lat_value,
    output logic              lat_busy
);
    localparam int QDEPTH = QUEUE_FRAMES * FRAME_LEN;
    localparam int IW     = (FRAME_LEN > 2) ? $clog2(FRAME_LEN) : 1;

    typedef struct packed {
        word_t         tx;
        logic          tx_loc;
        logic          loc_act;
        logic [IW-1:0] loc_idx;
    } state_t;

    state_t            q, d;
    word_t             in_word, pass_word;
    logic              line_busy, fin, fin_own, fin_err, fin_mark;
    logic [DATA_W-1:0] head;
    logic              frame_avail, pop, start_mark, local_go;
    logic [IW-1:0]     idx;
    logic              tx_from_local, local_active;

    assign in_word = '{vld: rx_valid, sop: rx_sop, eop: rx_eop, data: rx_data};

    ringfwd_delay #(.FRAME_LEN(FRAME_LEN)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_word  (in_word),
        .in_err   (rx_err),
        .node_id  (node_id),
        .out_word (pass_word),
        .line_busy(line_busy),
        .fin      (fin),
        .fin_own  (fin_own),
        .fin_err  (fin_err),
        .fin_mark (fin_mark)
    );

    ringfwd_lqueue #(.DEPTH(QDEPTH), .FRAME_LEN(FRAME_LEN)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (loc_valid),
        .push_data  (loc_data),
        .pop        (pop),
        .head       (head),
        .frame_avail(frame_avail),
        .not_full   (loc_ready)
    );

    always_comb begin
        d          = q;
        d.tx       = '0;
        d.tx_loc   = 1'b0;
        pop        = 1'b0;
        start_mark = 1'b0;
        local_go   = q.loc_act || (!pass_word.vld && frame_avail && !line_busy);
        idx        = q.loc_act ? q.loc_idx : '0;
        if (local_go) begin
            pop       = 1'b1;
            d.tx.vld  = 1'b1;
            d.tx.sop  = (idx == '0);
            d.tx.eop  = (idx == IW'(FRAME_LEN - 1));
            d.tx.data = head;
            d.tx_loc  = 1'b1;
            if (idx == '0) begin
                d.tx.data[ID_W-1:0] = node_id;
                start_mark          = head[MARK_BIT];
            end
            if (d.tx.eop) begin
                d.loc_act = 1'b0;
                d.loc_idx = '0;
            end else begin
                d.loc_act = 1'b1;
                d.loc_idx = idx + 1'b1;
            end
        end else if (pass_word.vld) begin
            d.tx = pass_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    ringfwd_monitor #(.CNT_W(CNT_W)) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .fin       (fin),
        .fin_own   (fin_own),
        .fin_err   (fin_err),
        .fin_mark  (fin_mark),
        .start_mark(start_mark),
        .alive_clr (alive_clr),
        .irq_en    (err_irq_en),
        .ring_alive(ring_alive),
        .err_irq   (err_irq),
        .lat_value (lat_value),
        .lat_busy  (lat_busy)
    );

    assign tx_valid      = q.tx.vld;
    assign tx_sop        = q.tx.sop;
    assign tx_eop        = q.tx.eop;
    assign tx_data       = q.tx.data;
    assign tx_from_local = q.tx_loc;
    assign local_active  = q.loc_act;
endmodule

// File: rtl/ringfwd_chk.sv
module ringfwd_chk #(
    parameter int FRAME_LEN = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  node_id,
    input logic        rx_valid,
    input logic        rx_eop,
    input logic        tx_valid,
    input logic        tx_sop,
    input logic        tx_eop,
    input logic [31:0] tx_data,
    input logic        tx_from_local,
    input logic        local_active,
    input logic        pass_vld,
    input logic        err_irq,
    input logic        ring_alive
);
    localparam int PW = $clog2(FRAME_LEN + 1);
    logic [PW-1:0] pos;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (tx_valid) begin
            pos <= tx_eop ? '0 : pos + 1'b1;
        end
    end

    AST_SOP_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_sop |-> pos == '0); // R1
    AST_EOP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_eop |-> pos == PW'(FRAME_LEN - 1)); // R1
    AST_FRAME_UNBROKEN: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_eop |=> tx_valid); // R1
    AST_OWN_NOT_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_sop && !tx_from_local |-> tx_data[7:0] != node_id); // R2
    AST_NO_COLLISION: assert property (@(posedge clk) disable iff (!rst_n)
        local_active |-> !pass_vld); // R5
    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> $past(rx_valid && rx_eop)); // R4
    AST_ALIVE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ring_alive) |-> $past(rx_valid && rx_eop)); // R7
endmodule

bind ringfwd_node ringfwd_chk #(.FRAME_LEN(FRAME_LEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .node_id      (node_id),
    .rx_valid     (rx_valid),
    .rx_eop       (rx_eop),
    .tx_valid     (tx_valid),
    .tx_sop       (tx_sop),
    .tx_eop       (tx_eop),
    .tx_data      (tx_data),
    .tx_from_local(tx_from_local),
    .local_active (local_active),
    .pass_vld     (pass_word.vld),
    .err_irq      (err_irq),
    .ring_alive   (ring_alive)
);

// File: tb/tb_ringfwd_node.sv
`timescale 1ns/1ps
module tb_ringfwd_node;
    localparam int L      = 4;
    localparam int QF     = 2;
    localparam int CW     = 16;
    localparam int LOOP_D = 3;
    localparam logic [7:0] MY_ID = 8'h2A;

    // {clr_before, origin[8], errpos[3] (7 = none), irq_en, exp_fwd, exp_irq, exp_alive}
    localparam logic [15:0] VEC [6] = '{
        {1'b0, 8'h10, 3'd7, 1'b1, 1'b1, 1'b0, 1'b0},
        {1'b0, 8'h2A, 3'd7, 1'b1, 1'b0, 1'b0, 1'b1},
        {1'b0, 8'h11, 3'd2, 1'b1, 1'b0, 1'b1, 1'b1},
        {1'b0, 8'h12, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1},
        {1'b1, 8'h2A, 3'd3, 1'b1, 1'b0, 1'b1, 1'b0},
        {1'b0, 8'hFE, 3'd7, 1'b1, 1'b1, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        drv_v = 0, drv_s = 0, drv_e = 0, drv_err = 0;
    logic [31:0] drv_d = '0;
    logic        loop_mode = 0;
    logic        loc_valid = 0;
    logic [31:0] loc_data = '0;
    logic        err_irq_en = 0, alive_clr = 0;

    logic        rx_valid, rx_sop, rx_eop, rx_err;
    logic [31:0] rx_data;
    logic        loc_ready, tx_valid, tx_sop, tx_eop, err_irq, ring_alive, lat_busy;
    logic [31:0] tx_data;
    logic [CW-1:0] lat_value;

    logic        lb_v [LOOP_D];
    logic        lb_s [LOOP_D];
    logic        lb_e [LOOP_D];
    logic [31:0] lb_d [LOOP_D];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < LOOP_D; k++) begin
                lb_v[k] <= 1'b0; lb_s[k] <= 1'b0; lb_e[k] <= 1'b0; lb_d[k] <= '0;
            end
        end else begin
            lb_v[0] <= tx_valid; lb_s[0] <= tx_sop; lb_e[0] <= tx_eop; lb_d[0] <= tx_data;
            for (int k = 1; k < LOOP_D; k++) begin
                lb_v[k] <= lb_v[k-1]; lb_s[k] <= lb_s[k-1];
                lb_e[k] <= lb_e[k-1]; lb_d[k] <= lb_d[k-1];
            end
        end
    end

    assign rx_valid = loop_mode ? lb_v[LOOP_D-1] : drv_v;
    assign rx_sop   = loop_mode ? lb_s[LOOP_D-1] : drv_s;
    assign rx_eop   = loop_mode ? lb_e[LOOP_D-1] : drv_e;
    assign rx_data  = loop_mode ? lb_d[LOOP_D-1] : drv_d;
    assign rx_err   = loop_mode ? 1'b0 : drv_err;

    ringfwd_node #(.FRAME_LEN(L), .QUEUE_FRAMES(QF), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .node_id(MY_ID),
        .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_data(rx_data), .rx_err(rx_err),
        .loc_valid(loc_valid), .loc_data(loc_data), .loc_ready(loc_ready),
        .tx_valid(tx_valid), .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_data(tx_data),
        .err_irq_en(err_irq_en), .err_irq(err_irq), .alive_clr(alive_clr),
        .ring_alive(ring_alive), .lat_value(lat_value), .lat_busy(lat_busy)
    );

    int checks = 0, errors = 0, cyc = 0;
    int ntx = 0, nirq = 0, bad = 0, wpos = 0, sent_cyc = 0;
    logic [31:0] curh;
    logic [31:0] txh [64];
    int          txc [64];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=finish", cyc);
            summary();
            $finish;
        end
    end

    // tx observer: frame integrity and header log (R1)
    always @(negedge clk) begin
        if (rst_n && err_irq) nirq++;
        if (rst_n && tx_valid) begin
            if (tx_sop) begin
                if (wpos != 0) bad++;
                curh = tx_data;
                if (ntx < 64) begin txh[ntx] = tx_data; txc[ntx] = cyc; end
                ntx++;
                wpos = 0;
            end else begin
                if (wpos == 0) bad++;
                if ((tx_data ^ (32'(wpos) << 24)) >> 8 != curh >> 8) bad++;
            end
            if (tx_eop) begin
                if (wpos != L - 1) bad++;
                wpos = 0;
            end else begin
                wpos++;
            end
        end else if (rst_n && wpos != 0) begin
            bad++;
            wpos = 0;
        end
    end

    function automatic logic [31:0] word_of(input logic [31:0] hdr, input int k);
        return (k == 0) ? hdr : hdr ^ (32'(k) << 24);
    endfunction

    task automatic send_frame(input logic [31:0] hdr, input int errpos, input bit clr_last);
        for (int k = 0; k < L; k++) begin
            @(negedge clk);
            if (k == 0) sent_cyc = cyc;
            drv_v = 1'b1; drv_s = (k == 0); drv_e = (k == L - 1);
            drv_d = word_of(hdr, k); drv_err = (k == errpos);
            alive_clr = clr_last && (k == L - 1);
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        drv_v = 0; drv_s = 0; drv_e = 0; drv_err = 0; alive_clr = 0;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic push_frame(input logic [31:0] hdr);
        for (int k = 0; k < L; k++) begin
            @(negedge clk);
            loc_valid = 1'b1;
            loc_data  = word_of(hdr, k);
        end
    endtask

    task automatic pulse_clr();
        @(negedge clk); alive_clr = 1'b1;
        @(negedge clk); alive_clr = 1'b0;
    endtask

    initial begin
        int n0, i0;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(tx_valid == 0, "R9 tx_valid", tx_valid, 0);
        chk(loc_ready == 1, "R9 loc_ready", loc_ready, 1);
        chk(ring_alive == 0, "R9 ring_alive", ring_alive, 0);
        chk(err_irq == 0, "R9 err_irq", err_irq, 0);
        chk(lat_value == 0 && lat_busy == 0, "R9 latency", lat_value, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table walk: R2 R3 R4 R7
        for (int i = 0; i < 6; i++) begin
            logic [15:0] v;
            logic [31:0] hdr;
            v = VEC[i];
            hdr = {8'hC0, 8'(i), 8'h00, v[14:7]};
            @(negedge clk);
            err_irq_en = v[3];
            if (v[15]) pulse_clr();
            n0 = ntx; i0 = nirq;
            send_frame(hdr, (v[6:4] == 3'd7) ? -1 : int'(v[6:4]), 1'b0);
            n0 = n0; // first word driven at sent_cyc
            idle(L + 4);
            chk((ntx - n0) == int'(v[2]), v[2] ? "R3 forwarded" : "R2/R4 removed", ntx - n0, v[2]);
            if (v[2]) begin
                chk(txh[n0] == hdr, "R3 header unchanged", txh[n0], hdr);
                chk(txc[n0] - sent_cyc == L + 1, "R3 latency", txc[n0] - sent_cyc, L + 1);
            end
            chk((nirq - i0) == int'(v[1]), "R4 err_irq pulses", nirq - i0, v[1]);
            chk(ring_alive == v[0], "R7 ring_alive", ring_alive, v[0]);
        end

        // R6 and R5: local frames wait behind a passing stream, queue fills
        n0 = ntx;
        fork
            begin
                send_frame(32'hA100_0031, -1, 1'b0);
                send_frame(32'hA200_0032, -1, 1'b0);
                send_frame(32'hA300_0033, -1, 1'b0);
                idle(1);
            end
            begin
                @(negedge clk);
                push_frame(32'hB100_00FF);
                push_frame(32'hB200_00FF);
                @(negedge clk);
                loc_valid = 1'b0;
                chk(loc_ready == 0, "R6 loc_ready low when full", loc_ready, 0);
            end
        join
        idle(30);
        chk(ntx - n0 == 5, "R5 frame count", ntx - n0, 5);
        chk(txh[n0] == 32'hA100_0031 && txh[n0+1] == 32'hA200_0032 && txh[n0+2] == 32'hA300_0033,
            "R5 upstream first", txh[n0+2], 32'hA300_0033);
        chk(txh[n0+3] == {24'hB10000, MY_ID}, "R5 local stamped", txh[n0+3], {24'hB10000, MY_ID});
        chk(txh[n0+4] == {24'hB20000, MY_ID}, "R5 second local", txh[n0+4], {24'hB20000, MY_ID});
        chk(loc_ready == 1, "R6 loc_ready after drain", loc_ready, 1);

        // R5: local frame fills the slot of a removed own frame
        n0 = ntx;
        fork
            begin
                send_frame(32'hA400_0041, -1, 1'b0);
                send_frame(32'hA500_002A, -1, 1'b0);
                send_frame(32'hA600_0043, -1, 1'b0);
                idle(1);
            end
            begin
                @(negedge clk);
                push_frame(32'hB300_00FF);
                @(negedge clk);
                loc_valid = 1'b0;
            end
        join
        idle(30);
        chk(ntx - n0 == 3, "R5 gap count", ntx - n0, 3);
        chk(txh[n0+1] == {24'hB30000, MY_ID}, "R5 local in gap", txh[n0+1], {24'hB30000, MY_ID});
        chk(txh[n0+2] == 32'hA600_0043, "R5 upstream after gap", txh[n0+2], 32'hA600_0043);
        chk(txc[n0+2] - txc[n0+1] == L, "R5 gap exactly filled", txc[n0+2] - txc[n0+1], L);

        // R8: round-trip latency through a loopback of LOOP_D registers
        pulse_clr();
        chk(ring_alive == 0, "R7 clear", ring_alive, 0);
        loop_mode = 1'b1;
        push_frame(32'hD000_01FF);
        @(negedge clk);
        loc_valid = 1'b0;
        repeat (25) @(negedge clk);
        chk(lat_value == CW'(LOOP_D + L), "R8 latency value", lat_value, LOOP_D + L);
        chk(lat_busy == 0, "R8 measurement done", lat_busy, 0);
        chk(ring_alive == 1, "R7 loop closed", ring_alive, 1);
        loop_mode = 1'b0;
        idle(4);

        // R7: clear and return on the same edge, set wins
        pulse_clr();
        chk(ring_alive == 0, "R7 cleared before", ring_alive, 0);
        send_frame(32'hE000_002A, -1, 1'b1);
        idle(2);
        chk(ring_alive == 1, "R7 set wins over clear", ring_alive, 1);

        chk(bad == 0, "R1 tx frame integrity", bad, 0);
        summary();
        $finish;
    end
endmodule